// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block collects a vector of interrupt sources (32 by default) and presents them to a processor on two request lines. Software configures each source through a small register bus. For each source it chooses how the source triggers, whether the source is enabled at all, whether it may raise a request, and which of the two request lines it drives. Every control register is changed only by writing ones to a paired set or clear address, so software never has to do a read-modify-write. Each source uses one of four trigger modes: rising edge, falling edge, active-high level or active-low level.

Edges are caught in sticky detect bits, and software acknowledges them by writing ones to an edge-clear address. A level-triggered source shows as pending for exactly as long as its input is asserted. For each request line a pending word can be read back, and software services the lowest-numbered set bit in it first. Inputs must already be synchronous to the clock. They are compared against their own value from the previous cycle to find edges.

Top module: `dual_req_intc`

## Requirements
- R1: Each source's mode is the code {c2,c1,c0} taken from bit i of the three configuration registers. Code 001 makes the source active after a rising edge, 010 after a falling edge. Code 101 makes it active while its input is 1, and 110 while its input is 0.
- R2: Codes 000, 011, 100 and 111 never make a source pending, whatever its input does.
- R3: Word addresses are c0 set/clear 0x0/0x1, c1 0x2/0x3, c2 0x4/0x5, request-enable 0x6/0x7, route 0x8/0x9 and source-enable 0xA/0xB. A write to a set address ORs the data into the register, and a write to a clear address removes the data's one bits. Zero data bits leave the register unchanged. Reading either address of a pair returns the register.
- R4: A source is pending only while its request-enable bit is 1.
- R5: While a source's source-enable bit is 0, the source is never pending and its edges are not recorded.
- R6: A pending source with route bit 1 appears in pend0_o, which is also readable at 0xD. A pending source with route bit 0 appears in pend1_o, readable at 0xE. No source appears in both.
- R7: An edge is recorded on the first clock at which the input differs from its value one clock earlier in the configured direction. Once recorded, the detect bit stays set until a write to 0xC carries a 1 in that bit position. Reading 0xC returns the detect bits.
- R8: An edge that arrives on the same clock as a clear of its detect bit leaves the bit set.
- R9: irq0_o is 1 exactly when pend0_o is non-zero, and irq1_o is 1 exactly when pend1_o is non-zero.
- R10: After reset, all configuration, enable, route and detect bits are 0, and so are both pending words.
- R11: A level source's pending bit follows its input in the same cycle and drops as soon as the input leaves its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NSRC | Synchronous interrupt source inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | NSRC | Write data, one bit per source |
| bus_rdata_o | output | NSRC | Read data for bus_addr_i |
| pend0_o | output | NSRC | Pending word of request line 0 |
| pend1_o | output | NSRC | Pending word of request line 1 |
| irq0_o | output | 1 | Request line 0 |
| irq1_o | output | 1 | Request line 1 |

## Verification
The bench drives an edge on the same clock as the clear of that source's detect bit. A design where the clear wins would lose that interrupt. It also writes clears whose data has zero bits over edges that are already latched, which catches a clear that wipes the whole register. It steps through all eight mode codes, including the unused ones. A decoder that looks at only two of the configuration bits would raise spurious pending bits for codes 011, 100 and 111. Finally it flips the route, the request-enable and the source-enable of a live source. A route with inverted polarity, or an edge still recorded while the source is disabled, shows up as a wrong pending word.

// File: rtl/dual_req_intc.sv
module dual_req_intc #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src_i,
  input  logic            bus_we_i,
  input  logic [3:0]      bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic [NSRC-1:0] pend0_o,
  output logic [NSRC-1:0] pend1_o,
  output logic            irq0_o,
  output logic            irq1_o
);
  localparam logic [3:0] A_C0S = 4'h0, A_C0C = 4'h1, A_C1S = 4'h2, A_C1C = 4'h3;
  localparam logic [3:0] A_C2S = 4'h4, A_C2C = 4'h5, A_MKS = 4'h6, A_MKC = 4'h7;
  localparam logic [3:0] A_RTS = 4'h8, A_RTC = 4'h9, A_ENS = 4'hA, A_ENC = 4'hB;
  localparam logic [3:0] A_DET = 4'hC, A_PD0 = 4'hD, A_PD1 = 4'hE;
  localparam logic [NSRC-1:0] ZERO = '0;

  logic [NSRC-1:0] c0_q, c1_q, c2_q, mask_q, route_q, en_q, det_q, prev_q;
  logic [NSRC-1:0] m_rise, m_fall, m_hi, m_lo, edge_evt, edge_clr, active, live;

  function automatic logic [NSRC-1:0] wsel(input logic we, input logic [3:0] a,
                                           input logic [3:0] tgt, input logic [NSRC-1:0] d);
    return (we && a == tgt) ? d : '0;
  endfunction

  assign m_rise = ~c2_q & ~c1_q &  c0_q;
  assign m_fall = ~c2_q &  c1_q & ~c0_q;
  assign m_hi   =  c2_q & ~c1_q &  c0_q;
  assign m_lo   =  c2_q &  c1_q & ~c0_q;

  assign edge_evt = en_q & ((m_rise & irq_src_i & ~prev_q) | (m_fall & ~irq_src_i & prev_q));
  assign edge_clr = wsel(bus_we_i, bus_addr_i, A_DET, bus_wdata_i);

  assign active = ((m_rise | m_fall) & det_q) | (m_hi & irq_src_i) | (m_lo & ~irq_src_i);
  assign live   = active & en_q & mask_q;
  assign pend0_o = live & route_q;
  assign pend1_o = live & ~route_q;
  assign irq0_o  = |pend0_o;
  assign irq1_o  = |pend1_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0; c1_q <= '0; c2_q <= '0; mask_q <= '0;
      route_q <= '0; en_q <= '0; det_q <= '0; prev_q <= '0;
    end else begin
      c0_q    <= (c0_q    | wsel(bus_we_i, bus_addr_i, A_C0S, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_C0C, bus_wdata_i);
      c1_q    <= (c1_q    | wsel(bus_we_i, bus_addr_i, A_C1S, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_C1C, bus_wdata_i);
      c2_q    <= (c2_q    | wsel(bus_we_i, bus_addr_i, A_C2S, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_C2C, bus_wdata_i);
      mask_q  <= (mask_q  | wsel(bus_we_i, bus_addr_i, A_MKS, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_MKC, bus_wdata_i);
      route_q <= (route_q | wsel(bus_we_i, bus_addr_i, A_RTS, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_RTC, bus_wdata_i);
      en_q    <= (en_q    | wsel(bus_we_i, bus_addr_i, A_ENS, bus_wdata_i)) & ~wsel(bus_we_i, bus_addr_i, A_ENC, bus_wdata_i);
      det_q   <= (det_q & ~edge_clr) | edge_evt;
      prev_q  <= irq_src_i;
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_C0S, A_C0C: bus_rdata_o = c0_q;
      A_C1S, A_C1C: bus_rdata_o = c1_q;
      A_C2S, A_C2C: bus_rdata_o = c2_q;
      A_MKS, A_MKC: bus_rdata_o = mask_q;
      A_RTS, A_RTC: bus_rdata_o = route_q;
      A_ENS, A_ENC: bus_rdata_o = en_q;
      A_DET:        bus_rdata_o = det_q;
      A_PD0:        bus_rdata_o = pend0_o;
      A_PD1:        bus_rdata_o = pend1_o;
      default:      bus_rdata_o = '0;
    endcase
  end

  always_comb begin
    if (rst_n) begin
      AST_PEND_DISJOINT: assert ((pend0_o & pend1_o) == ZERO); // R6
      AST_PEND_NEEDS_MASK: assert (((pend0_o | pend1_o) & ~mask_q) == ZERO); // R4
      AST_PEND_NEEDS_EN: assert (((pend0_o | pend1_o) & ~en_q) == ZERO); // R5
      AST_BAD_CODE_QUIET: assert (((pend0_o | pend1_o) & ~(m_rise | m_fall | m_hi | m_lo)) == ZERO); // R2
    end
  end

  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(det_q) & ~$past(edge_clr) & ~det_q) == ZERO)); // R7
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_evt) & ~det_q) == ZERO)); // R8
  AST_NO_DET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ~$past(det_q) & ~$past(en_q)) == ZERO)); // R5
endmodule

// File: tb/dual_req_intc_tb_top.sv
`timescale 1ns/1ps
module dual_req_intc_tb_top;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, wdata = '0;
  logic we = 0;
  logic [3:0] addr = 4'hD;
  logic [N-1:0] rdata, p0, p1;
  logic i0, i1;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_c0, m_c1, m_c2, m_mk, m_rt, m_en, m_det, m_prev;

  always #2.5 clk = ~clk;

  dual_req_intc #(.NSRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pend0_o(p0), .pend1_o(p1),
    .irq0_o(i0), .irq1_o(i1));

  function automatic logic src_active(input logic [2:0] code, input logic in, input logic det);
    case (code)
      3'b001, 3'b010: return det;
      3'b101: return in;
      3'b110: return !in;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_pend(input logic line);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_mk[i] && (m_rt[i] == !line) &&
          src_active({m_c2[i], m_c1[i], m_c0[i]}, src[i], m_det[i])) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0, 4'h1: return m_c0;
      4'h2, 4'h3: return m_c1;
      4'h4, 4'h5: return m_c2;
      4'h6, 4'h7: return m_mk;
      4'h8, 4'h9: return m_rt;
      4'hA, 4'hB: return m_en;
      4'hC: return m_det;
      4'hD: return exp_pend(1'b0);
      4'hE: return exp_pend(1'b1);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_clock();
    logic [N-1:0] s, c;
    for (int i = 0; i < N; i++) begin
      logic [2:0] code = {m_c2[i], m_c1[i], m_c0[i]};
      logic ev = m_en[i] && ((code == 3'b001 && src[i] && !m_prev[i]) ||
                             (code == 3'b010 && !src[i] && m_prev[i]));
      logic cl = we && addr == 4'hC && wdata[i];
      m_det[i] = ev || (m_det[i] && !cl);
    end
    s = we ? wdata : '0;
    c = s;
    case (addr)
      4'h0: m_c0 |= s;  4'h1: m_c0 &= ~c;
      4'h2: m_c1 |= s;  4'h3: m_c1 &= ~c;
      4'h4: m_c2 |= s;  4'h5: m_c2 &= ~c;
      4'h6: m_mk |= s;  4'h7: m_mk &= ~c;
      4'h8: m_rt |= s;  4'h9: m_rt &= ~c;
      4'hA: m_en |= s;  4'hB: m_en &= ~c;
      default: ;
    endcase
    m_prev = src;
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    model_clock();
    chk({tag, " pend0"}, p0, exp_pend(1'b0));
    chk({tag, " pend1"}, p1, exp_pend(1'b1));
    chk({tag, " R9 irq"}, {30'd0, i1, i0}, {30'd0, |exp_pend(1'b1), |exp_pend(1'b0)});
    chk({tag, " R3 read"}, rdata, exp_read(addr));
  endtask

  task automatic drv(input string tag, input logic w, input logic [3:0] a,
                     input logic [N-1:0] d, input logic [N-1:0] s);
    we = w; addr = a; wdata = d; src = s;
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    {m_c0, m_c1, m_c2, m_mk, m_rt, m_en, m_det, m_prev} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 16; a++) begin
      we = 0; addr = a[3:0];
      step("R10 reset");
    end
    drv("R3", 1, 4'h0, 32'hF0F0_F0F0, '0);
    drv("R3", 1, 4'h0, 32'h0000_FFFF, '0);
    drv("R3", 1, 4'h1, 32'h00F0_00F0, '0);
    drv("R3", 0, 4'h1, '0, '0);
    drv("R3", 1, 4'h1, 32'hFFFF_FFFF, '0);
    // modes: s0 001, s1 010, s2 101, s3 110, s4 011, s5 100, s6 111
    drv("R1", 1, 4'h0, 32'h55, '0);
    drv("R1", 1, 4'h2, 32'h5A, '0);
    drv("R1", 1, 4'h4, 32'h6C, '0);
    drv("R1", 1, 4'h6, 32'h7F, '0);
    drv("R6", 1, 4'h8, 32'h0F, '0);
    drv("R5", 0, 4'hD, '0, 32'h01);
    drv("R5", 0, 4'hC, '0, 32'h00);
    drv("R5", 1, 4'hA, 32'h7F, 32'h00);
    drv("R1", 0, 4'hD, '0, 32'h01);
    drv("R1", 0, 4'hD, '0, 32'h03);
    drv("R1", 0, 4'hD, '0, 32'h01);
    drv("R11", 0, 4'hD, '0, 32'h05);
    drv("R11", 0, 4'hD, '0, 32'h09);
    drv("R2", 0, 4'hE, '0, 32'h71);
    drv("R2", 0, 4'hE, '0, 32'h01);
    drv("R2", 0, 4'hE, '0, 32'h71);
    drv("R7", 1, 4'hC, 32'hFFFF_FFFE, 32'h01);
    drv("R7", 0, 4'hC, '0, 32'h01);
    drv("R7", 1, 4'hC, 32'h1, 32'h00);
    drv("R8", 1, 4'hC, 32'h1, 32'h01);
    drv("R8", 0, 4'hC, '0, 32'h01);
    drv("R4", 1, 4'h7, 32'h04, 32'h05);
    drv("R4", 1, 4'h6, 32'h04, 32'h05);
    drv("R6", 1, 4'h9, 32'h04, 32'h05);
    drv("R6", 0, 4'hE, '0, 32'h05);
    drv("R5", 1, 4'hB, 32'h04, 32'h05);
    drv("R11", 0, 4'hD, '0, 32'h08);
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s = src ^ ($urandom & $urandom & $urandom);
      logic w = ($urandom % 3) == 0;
      logic [3:0] a = 4'($urandom);
      drv("RND", w, a, $urandom, s);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule